// File: doc/BRIEF.md
# Repeating Far-End Alarm Code Transmitter

This block sends a six-bit alarm or control code to the far end of a framed serial link. When the host issues a start command, the block freezes the current code, wraps it into a sixteen-bit message and places one message bit into the alarm slot of each outgoing frame. The frame generator marks every such slot with a one-cycle strobe. The message goes out ten times back to back, and then the block returns to idle. While idle, the slot carries a steady mark of 1s.

The host uses a two-register interface. A control/status register holds the enable bit, the start command, a busy flag and a completion flag that latches and clears on read. A code register holds the six-bit code. Reads are combinational from the address. A read strobe marks the cycle in which a read takes effect, so the completion flag clears only on a real access.

Top module: `feac_tx`

## Requirements
- R1: Code register at address 1: the code occupies bits 6..1, is readable and writable, and bits 7 and 0 always read 0.
- R2: Each message is sixteen bits, sent in this order: a 0, the six code bits least significant first, a 0, then eight 1s.
- R3: The alarm output presents one message bit per frame strobe. The position advances only on a cycle with the strobe high, so a gap in strobes holds the current bit.
- R4: A start sends the message exactly ten times consecutively. After that, every slot carries 1.
- R5: A start (control bit 1 written as 1) is accepted only if the enable bit (control bit 2) is written as 1 in the same write. Otherwise nothing is sent, and the idle alarm output is 1.
- R6: Control bit 0 (busy) reads 1 from the cycle after an accepted start until the strobe that carries the last bit of the tenth repeat, and 0 afterwards.
- R7: Control bit 3 (completion) is set when the tenth repeat finishes and cleared by a read of the control register. A completion that coincides with the read leaves it set.
- R8: The code is captured when the start is accepted, so writes to the code register during a transmission do not alter it.
- R9: A start written while busy is ignored and does not restart the message.
- R10: Writing the enable bit as 0 while busy aborts the transmission at once, returns to idle and does not set the completion flag.
- R11: The control register reads back the enable bit in bit 2, and reads 0 in bit 1 and in bits 7..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears the completion flag) |
| host_addr | input | 1 | Register address: 0 control/status, 1 code |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| slot_strobe | input | 1 | One-cycle pulse marking each outgoing alarm slot |
| alarm_bit | output | 1 | Bit to place in the current alarm slot |

## Verification
A wrong bit or repeat counter shows on the very next strobe as a misplaced or extra bit in the alarm stream. The scoreboard compares every slot against the expected message sequence, so it catches the fault within one frame. A corrupted shadow code appears in the first code-bit slot after the error. A wrong busy or completion state shows at the first control read after the expected end of transmission. An abort that leaves the sequencer running shows as non-mark bits in the slot right after the enable clear.

// File: rtl/feac_pkg.sv
package feac_pkg;

  // register addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CODE = 1;

  // control/status bit positions
  localparam int unsigned CTRL_BUSY = 0;
  localparam int unsigned CTRL_GO   = 1;
  localparam int unsigned CTRL_EN   = 2;
  localparam int unsigned CTRL_DONE = 3;

  // fixed framing around the code word
  localparam int unsigned FRAMING_BITS = 10;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_e;

endpackage

// File: rtl/feac_regs.sv
module feac_regs
  import feac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy_i,
  input  logic              done_pulse_i,
  output logic [CODE_W-1:0] code_o,
  output logic              start_o,
  output logic              abort_o
);

  logic              enable_q, enable_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              done_q, done_d;
  logic              ctrl_wr, code_wr, ctrl_rd;

  assign ctrl_wr = host_wr && (host_addr == 1'(ADDR_CTRL));
  assign code_wr = host_wr && (host_addr == 1'(ADDR_CODE));
  assign ctrl_rd = host_rd && (host_addr == 1'(ADDR_CTRL));

  // command decode
  always_comb begin
    start_o = ctrl_wr && host_wdata[CTRL_GO] && host_wdata[CTRL_EN] && !busy_i;
    abort_o = ctrl_wr && !host_wdata[CTRL_EN] && busy_i;
  end

  // next-state
  always_comb begin
    enable_d = enable_q;
    code_d   = code_q;
    done_d   = done_q;
    if (ctrl_wr) enable_d = host_wdata[CTRL_EN];
    if (code_wr) code_d   = host_wdata[CODE_W:1];
    if (done_pulse_i)  done_d = 1'b1;
    else if (ctrl_rd)  done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      code_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      enable_q <= enable_d;
      if (code_wr) code_q <= code_d;
      done_q   <= done_d;
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    if (host_addr == 1'(ADDR_CTRL)) begin
      host_rdata[CTRL_BUSY] = busy_i;
      host_rdata[CTRL_EN]   = enable_q;
      host_rdata[CTRL_DONE] = done_q;
    end else begin
      host_rdata[CODE_W:1] = code_q;
    end
  end

  assign code_o = code_q;

  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_i |=> done_q);                                   // R7
  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !start_o);                                       // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !done_pulse_i) |=> !done_q);                    // R7

endmodule

// File: rtl/feac_seq.sv
module feac_seq
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic              done_pulse_o,
  output logic              tx_bit_o
);

  localparam int unsigned MSG_W = CODE_W + FRAMING_BITS;
  localparam int unsigned BIT_W = $clog2(MSG_W);
  localparam int unsigned REP_W = $clog2(REPEATS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(MSG_W - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPEATS - 1);

  seq_state_e       state_q, state_d;
  logic [MSG_W-1:0] msg_q, msg_new;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             load;

  // message assembly: start 0, code LSB first, 0, then all ones
  always_comb begin
    msg_new             = '1;
    msg_new[0]          = 1'b0;
    msg_new[CODE_W:1]   = code_i;
    msg_new[CODE_W+1]   = 1'b0;
  end

  // next-state
  always_comb begin
    state_d      = state_q;
    bit_d        = bit_q;
    rep_d        = rep_q;
    load         = 1'b0;
    done_pulse_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_SEND;
          bit_d   = '0;
          rep_d   = '0;
          load    = 1'b1;
        end
      end
      SEQ_SEND: begin
        if (abort_i) begin
          state_d = SEQ_IDLE;
        end else if (strobe_i) begin
          if (bit_q == LAST_BIT) begin
            bit_d = '0;
            if (rep_q == LAST_REP) begin
              state_d      = SEQ_IDLE;
              done_pulse_o = 1'b1;
            end else begin
              rep_d = rep_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      bit_q   <= '0;
      rep_q   <= '0;
      msg_q   <= '1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      rep_q   <= rep_d;
      if (load) msg_q <= msg_new;
    end
  end

  assign busy_o   = (state_q == SEQ_SEND);
  assign tx_bit_o = busy_o ? msg_q[bit_q] : 1'b1;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_bit_o);                                      // R5
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !strobe_i && !abort_i) |=> ($stable(bit_q) && $stable(rep_q) && busy_o)); // R3
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(msg_q));                                 // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |=> !busy_o);                                  // R6
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q <= LAST_BIT) && (rep_q <= LAST_REP));                // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> !busy_o);                           // R10

endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              slot_strobe,
  output logic              alarm_bit
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CODE_W-1:0] code;
  logic              start, abort, busy, done_pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  feac_regs #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .busy_i       (busy),
    .done_pulse_i (done_pulse),
    .code_o       (code),
    .start_o      (start),
    .abort_o      (abort)
  );

  feac_seq #(
    .CODE_W  (CODE_W),
    .REPEATS (REPEATS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start),
    .abort_i      (abort),
    .strobe_i     (slot_strobe),
    .code_i       (code),
    .busy_o       (busy),
    .done_pulse_o (done_pulse),
    .tx_bit_o     (alarm_bit)
  );

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    abort |-> !done_pulse);                                     // R10
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> busy);                                            // R6

endmodule

// File: tb/feac_tx_tb.sv
`timescale 1ns/100ps
module feac_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       slot_strobe = 1'b0;
  logic       alarm_bit;

  int   checks = 0;
  int   fails  = 0;
  bit   frames_on = 1'b0;
  int   frame_period = 4;
  bit   exp_q[$];

  always #2.5 clk = ~clk;

  feac_tx u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .slot_strobe (slot_strobe),
    .alarm_bit   (alarm_bit)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // driver: issue a start and push the expected slot stream
  task automatic send_code(input logic [5:0] code);
    reg_write(1'b1, {1'b0, code, 1'b0});
    reg_write(1'b0, 8'h06);
    for (int r = 0; r < 10; r++) begin
      exp_q.push_back(1'b0);
      for (int b = 0; b < 6; b++) exp_q.push_back(code[b]);
      exp_q.push_back(1'b0);
      for (int b = 0; b < 8; b++) exp_q.push_back(1'b1);
    end
  endtask

  // slot generator and monitor
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      if (frames_on && gap == 0) begin
        bit exp;
        slot_strobe = 1'b1;
        #1;
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
        check("R2 R3 R4 alarm slot", alarm_bit, exp);
      end else begin
        slot_strobe = 1'b0;
      end
      gap = frames_on ? (gap + 1) % frame_period : 0;
    end
  end

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    reg_read(1'b0, rd); check("R11 ctrl after reset", rd, 8'h00);
    reg_read(1'b1, rd); check("R1 code after reset", rd, 8'h00);
    frames_on = 1'b1;

    // R1 code register field layout
    reg_write(1'b1, 8'hFF); reg_read(1'b1, rd); check("R1 code all ones", rd, 8'h7E);
    reg_write(1'b1, 8'h81); reg_read(1'b1, rd); check("R1 reserved bits", rd, 8'h00);

    // R5 start without enable is ignored
    reg_write(1'b0, 8'h02);
    reg_read(1'b0, rd); check("R5 go without enable", rd, 8'h00);
    repeat (40) @(negedge clk);

    // R11 enable readback, go bit reads 0
    reg_write(1'b0, 8'hF4);
    reg_read(1'b0, rd); check("R11 enable readback", rd, 8'h04);

    // first message, with mid-message code write and repeated go
    send_code(6'h2D);
    reg_read(1'b0, rd); check("R6 busy after go", rd, 8'h05);
    repeat (60) @(negedge clk);
    reg_write(1'b1, {1'b0, 6'h12, 1'b0});   // R8
    reg_write(1'b0, 8'h06);                 // R9
    drain();
    reg_read(1'b0, rd); check("R6 R7 busy low, done set", rd, 8'h0C);
    reg_read(1'b0, rd); check("R7 done cleared by read", rd, 8'h04);

    // R3 different slot spacing and a pause in strobes
    frame_period = 3;
    send_code(6'h3F);
    repeat (100) @(negedge clk);
    frames_on = 1'b0;
    repeat (40) @(negedge clk);
    reg_read(1'b0, rd); check("R3 busy held through strobe gap", rd, 8'h05);
    frames_on = 1'b1;
    drain();
    reg_read(1'b0, rd); check("R7 done after second message", rd, 8'h0C);

    // all-zero code
    frame_period = 5;
    send_code(6'h00);
    drain();
    reg_read(1'b0, rd); check("R4 done after third message", rd, 8'h0C);

    // R10 abort by clearing enable
    frame_period = 4;
    send_code(6'h15);
    repeat (90) @(negedge clk);
    reg_write(1'b0, 8'h00);
    exp_q.delete();
    reg_read(1'b0, rd); check("R10 idle after abort", rd, 8'h00);
    repeat (200) @(negedge clk);
    reg_read(1'b0, rd); check("R10 no done after abort", rd, 8'h00);

    // R5 go with enable written 0 while idle
    reg_write(1'b0, 8'h02);
    repeat (40) @(negedge clk);
    reg_read(1'b0, rd); check("R5 still idle", rd, 8'h00);

    frames_on = 1'b0;
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule